// File: doc/BRIEF.md
# Serial EEPROM Address-Width Autosizer

This block is the host-side controller for a three-wire serial EEPROM. It drives chip select, serial clock and serial data toward the device and samples the device's data line. The device's address width is not assumed. A probe request measures it at run time by watching for the zero bit that the device drives once it has taken its last address bit. Word reads then shift exactly the measured number of address bits and return 16-bit words.

The user side has three requests. A probe request runs the size detection. A read request carries a start word address and a word count minus one. The clock divider input sets the serial clock half-period. The block reports the measured width, one-cycle valid pulses carrying read data, a busy flag and a one-cycle done pulse.

The controller is a state machine with seven states:

- IDLE waits for a request.
- SEL raises chip select for one half-period.
- OPC shifts the read opcode.
- PROBE shifts zero address bits and samples the device after each one.
- ADDR shifts the read address.
- DATA collects the data bits.
- DESEL drops chip select for one half-period.

The transitions are:

- IDLE→SEL on a request.
- SEL→OPC after one half-period.
- OPC→PROBE or OPC→ADDR after the third opcode bit, depending on the request.
- PROBE→DESEL on a zero sample or on the last allowed probe bit.
- ADDR→DATA after the last address bit.
- DATA→DESEL after the sixteenth data bit.
- DESEL→SEL when words remain in a read.
- DESEL→IDLE otherwise.

Top module: `eeprom_awidth_ctrl`

## Requirements
- R1: After reset, chip select, serial clock, data-in, busy, done and rd_valid are low, and the recorded address width is 6.
- R2: Each high phase and each low phase of the serial clock lasts clk_div+1 clock cycles. Data-in changes only while the serial clock is low.
- R3: Every transaction begins with the 3-bit read opcode 110 (start bit 1, then 1, then 0), shifted most significant bit first while chip select is high. The serial clock is high only while chip select is high.
- R4: A probe shifts zero address bits one at a time and samples data-out at the end of each clock-high phase. The recorded width is the number of address bits shifted up to and including the first bit whose sample reads 0. The probe transaction then holds exactly 3 + width rising clock edges.
- R5: If data-out still reads 1 after the eighth probe bit (MAX_AW), probing stops there and the recorded width is MAX_AW+1 (9). The width never leaves the range 1 to MAX_AW+1.
- R6: At the end of each probe and each word read, chip select, serial clock and data-in return low. They stay low whenever the block is idle.
- R7: A read shifts exactly `width` address bits, most significant first, taken from the low bits of the word address. Address bit positions above rd_addr's width are sent as 0. Before any probe, reads use width 6.
- R8: After the address, each word read takes 16 data bits, most significant first, each sampled at the end of a clock-high phase. A word transaction holds 3 + width + 16 rising edges. The word appears on rd_data with a one-cycle rd_valid pulse.
- R9: A read request returns rd_len+1 words from consecutive addresses. Each word is a separate chip-select transaction.
- R10: busy is high from the cycle after a request until the cycle done pulses; in that cycle busy is low. done is a one-cycle pulse. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Serial clock half-period in clock cycles, minus one |
| probe_req | input | 1 | Start address-width detection |
| rd_req | input | 1 | Start a read |
| rd_addr | input | MAX_AW | First word address of a read |
| rd_len | input | LEN_W | Number of words to read, minus one |
| rd_data | output | DATA_W | Last word read |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| aw_width | output | WW | Recorded address width |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM (pulled high when undriven) |

## Verification
The bench builds the block with its defaults: MAX_AW = 8, DATA_W = 16, LEN_W = 4 and DIV_W = 4. Its behavioural EEPROM model can be set to 6, 8 or 10 address bits. With MAX_AW at 8, a 10-bit device runs the probe past its limit, so the width of 9 is reached. The 6- and 8-bit devices exercise both expected widths, the legacy default before any probe, and a three-word read. Divider values 0, 1 and 2 exercise the half-period timing.

// File: rtl/eeprom_awidth_pkg.sv
package eeprom_awidth_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEL,
        S_OPC,
        S_PROBE,
        S_ADDR,
        S_DATA,
        S_DESEL
    } ew_state_t;

    localparam logic [2:0] READ_OPC  = 3'b110;
    localparam int         OPC_BITS  = 3;
    localparam int         LEGACY_AW = 6;

endpackage

// File: rtl/ew_halfper_tick.sv
module ew_halfper_tick #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (!run || cnt_q == '0)  cnt_q <= div;
        else                           cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/ew_seq.sv
module ew_seq
    import eeprom_awidth_pkg::*;
#(
    parameter int MAX_AW = 8,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    localparam int WW    = $clog2(MAX_AW + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              probe_req,
    input  logic              rd_req,
    input  logic [MAX_AW-1:0] rd_addr,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic              do_i,
    output logic              cs,
    output logic              sk,
    output logic              di,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [WW-1:0]     width,
    output logic              busy,
    output logic              done
);
    localparam int BMAX = (DATA_W > MAX_AW + 1) ? DATA_W : MAX_AW + 1;
    localparam int CW   = $clog2(BMAX + 1);
    localparam int AIW  = $clog2(MAX_AW + 1);
    localparam logic [CW-1:0] PROBE_LAST = CW'(MAX_AW - 1);
    localparam logic [CW-1:0] DATA_LAST  = CW'(DATA_W - 1);
    localparam logic [CW-1:0] OPC_LAST   = CW'(OPC_BITS - 1);

    ew_state_t         st_q, st_d;
    logic              hi_q, probe_q;
    logic [CW-1:0]     bcnt_q;
    logic [MAX_AW-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [DATA_W-1:0] sh_q;
    logic [MAX_AW:0]   addr_ext;
    logic              is_bit, last_bit, bcnt_zero;

    assign is_bit    = (st_q == S_OPC) || (st_q == S_PROBE) ||
                       (st_q == S_ADDR) || (st_q == S_DATA);
    assign last_bit  = tick && hi_q;
    assign bcnt_zero = (bcnt_q == '0);
    assign addr_ext  = {1'b0, addr_q};
    assign busy      = (st_q != S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (probe_req || rd_req) st_d = S_SEL;
            S_SEL:   if (tick) st_d = S_OPC;
            S_OPC:   if (last_bit && bcnt_zero) st_d = probe_q ? S_PROBE : S_ADDR;
            S_PROBE: if (last_bit && (!do_i || bcnt_q == PROBE_LAST)) st_d = S_DESEL;
            S_ADDR:  if (last_bit && bcnt_zero) st_d = S_DATA;
            S_DATA:  if (last_bit && bcnt_zero) st_d = S_DESEL;
            S_DESEL: if (tick) st_d = (!probe_q && left_q != '0) ? S_SEL : S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // outputs toward the device
    always_comb begin
        cs = 1'b0;
        sk = 1'b0;
        di = 1'b0;
        unique case (st_q)
            S_SEL:   cs = 1'b1;
            S_OPC:   begin cs = 1'b1; sk = hi_q; di = READ_OPC[bcnt_q[1:0]]; end
            S_PROBE: begin cs = 1'b1; sk = hi_q; end
            S_ADDR:  begin cs = 1'b1; sk = hi_q; di = addr_ext[bcnt_q[AIW-1:0]]; end
            S_DATA:  begin cs = 1'b1; sk = hi_q; end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q     <= 1'b0;
            probe_q  <= 1'b0;
            bcnt_q   <= '0;
            addr_q   <= '0;
            left_q   <= '0;
            sh_q     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            width    <= WW'(LEGACY_AW);
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            if (!is_bit)   hi_q <= 1'b0;
            else if (tick) hi_q <= !hi_q;
            unique case (st_q)
                S_IDLE: begin
                    if (probe_req) begin
                        probe_q <= 1'b1;
                    end else if (rd_req) begin
                        probe_q <= 1'b0;
                        addr_q  <= rd_addr;
                        left_q  <= rd_len;
                    end
                end
                S_SEL: if (tick) bcnt_q <= OPC_LAST;
                S_OPC: if (last_bit) begin
                    if (!bcnt_zero)   bcnt_q <= bcnt_q - 1'b1;
                    else if (probe_q) bcnt_q <= '0;
                    else              bcnt_q <= CW'(width) - 1'b1;
                end
                S_PROBE: if (last_bit) begin
                    if (!do_i)                     width <= WW'(bcnt_q + 1'b1);
                    else if (bcnt_q == PROBE_LAST) width <= WW'(MAX_AW + 1);
                    bcnt_q <= bcnt_q + 1'b1;
                end
                S_ADDR: if (last_bit) bcnt_q <= bcnt_zero ? DATA_LAST : bcnt_q - 1'b1;
                S_DATA: if (last_bit) begin
                    sh_q   <= {sh_q[DATA_W-2:0], do_i};
                    bcnt_q <= bcnt_q - 1'b1;
                    if (bcnt_zero) begin
                        rd_data  <= {sh_q[DATA_W-2:0], do_i};
                        rd_valid <= 1'b1;
                    end
                end
                S_DESEL: if (tick) begin
                    if (!probe_q && left_q != '0) begin
                        left_q <= left_q - 1'b1;
                        addr_q <= addr_q + 1'b1;
                    end else begin
                        done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_awidth_ctrl.sv
module eeprom_awidth_ctrl #(
    parameter int MAX_AW = 8,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    parameter int DIV_W  = 4,
    localparam int WW    = $clog2(MAX_AW + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              probe_req,
    input  logic              rd_req,
    input  logic [MAX_AW-1:0] rd_addr,
    input  logic [LEN_W-1:0]  rd_len,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [WW-1:0]     aw_width,
    output logic              busy,
    output logic              done,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic tick;

    ew_halfper_tick #(.DIV_W(DIV_W)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (clk_div),
        .tick (tick)
    );

    ew_seq #(.MAX_AW(MAX_AW), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .probe_req(probe_req),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_len   (rd_len),
        .do_i     (ee_do),
        .cs       (ee_cs),
        .sk       (ee_sk),
        .di       (ee_di),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .width    (aw_width),
        .busy     (busy),
        .done     (done)
    );
endmodule

// File: rtl/ew_checker.sv
module ew_checker #(
    parameter int MAX_AW = 8,
    parameter int WW     = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          probe_req,
    input logic          ee_cs,
    input logic          ee_sk,
    input logic          ee_di,
    input logic          busy,
    input logic          done,
    input logic          rd_valid,
    input logic [WW-1:0] aw_width
);
    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);                                                // R3
    AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));                      // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_sk && !ee_di));                          // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                  // R10
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                            // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R10
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                          // R8
    AST_WIDTH_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !probe_req) |=> $stable(aw_width));                     // R4
    AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_width >= 1) && (32'(aw_width) <= MAX_AW + 1));               // R5
endmodule

bind eeprom_awidth_ctrl ew_checker #(.MAX_AW(MAX_AW), .WW(WW)) i_ew_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .probe_req(probe_req),
    .ee_cs    (ee_cs),
    .ee_sk    (ee_sk),
    .ee_di    (ee_di),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .aw_width (aw_width)
);

// File: tb/test_eeprom_awidth_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_awidth_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  clk_div = 4'd1;
    logic        probe_req = 1'b0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [3:0]  rd_len = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [3:0]  aw_width;
    logic        busy, done, ee_cs, ee_sk, ee_di;
    logic        ee_do;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_awidth_ctrl i_eeprom_awidth_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .probe_req(probe_req),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .rd_data(rd_data),
        .rd_valid(rd_valid), .aw_width(aw_width), .busy(busy), .done(done),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // ---------------- behavioural EEPROM model ----------------
    int          dev_aw = 6;
    int          nb = 0;
    int          last_nb = 0;
    int          txn = 0;
    int          bad_op = 0;
    logic [2:0]  op_m = '0;
    logic [15:0] addr_m = '0;
    logic [15:0] word_m = '0;
    logic        do_m = 1'b1;

    assign ee_do = do_m;

    function automatic logic [15:0] mem(input int a);
        logic [15:0] v;
        v = 16'(a);
        return 16'h9C35 ^ (v * 16'h0241) ^ {v[7:0], 8'h00};
    endfunction

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            if (nb > 0) begin
                txn = txn + 1;
                last_nb = nb;
            end
            nb = 0; do_m = 1'b1; op_m = '0; addr_m = '0;
        end else begin
            nb = nb + 1;
            if (nb <= 3) begin
                op_m = {op_m[1:0], ee_di};
                if (nb == 3 && op_m != 3'b110) bad_op = bad_op + 1;
            end else if (nb <= 3 + dev_aw) begin
                addr_m = {addr_m[14:0], ee_di};
                if (nb == 3 + dev_aw) begin
                    do_m = 1'b0;
                    word_m = mem(int'(addr_m));
                end
            end else if (nb <= 3 + dev_aw + 16) begin
                do_m = word_m[15 - (nb - 4 - dev_aw)];
            end else begin
                do_m = 1'b1;
            end
        end
    end

    // ---------------- monitors ----------------
    logic [15:0] got [0:15];
    int gi = 0;
    int hcnt = 0, lcnt = 0;
    int hmin = 1000, hmax = 0, lmin = 1000, lmax = 0;
    always @(negedge clk) begin
        if (rd_valid && gi < 16) begin
            got[gi] = rd_data;
            gi = gi + 1;
        end
        if (ee_sk) begin
            hcnt = hcnt + 1;
            if (lcnt != 0) begin
                if (lcnt < lmin) lmin = lcnt;
                if (lcnt > lmax) lmax = lcnt;
            end
            lcnt = 0;
        end else begin
            if (hcnt != 0) begin
                if (hcnt < hmin) hmin = hcnt;
                if (hcnt > hmax) hmax = hcnt;
                lcnt = 1;
            end else if (lcnt != 0 && ee_cs) begin
                lcnt = lcnt + 1;
            end else begin
                lcnt = 0;
            end
            hcnt = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic clear_mon();
        gi = 0; txn = 0; bad_op = 0;
        hmin = 1000; hmax = 0; lmin = 1000; lmax = 0;
    endtask

    int busy_gap;
    task automatic wait_done();
        busy_gap = 0;
        @(negedge clk);
        while (!done) begin
            if (!busy) busy_gap = busy_gap + 1;
            @(negedge clk);
        end
    endtask

    task automatic pulse_probe();
        @(negedge clk); probe_req = 1'b1;
        @(negedge clk); probe_req = 1'b0;
    endtask

    task automatic pulse_read(input int a, input int len);
        @(negedge clk); rd_addr = 8'(a); rd_len = 4'(len); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(!ee_cs && !ee_sk && !ee_di, "R1 lines low", {ee_cs, ee_sk, ee_di}, 0);
        check(!busy && !done && !rd_valid, "R1 flags low", {busy, done, rd_valid}, 0);
        check(aw_width == 4'd6, "R1 legacy width", aw_width, 6);
    endtask

    task automatic t_probe(input int aw, input int div, input int expw);
        dev_aw = aw; clk_div = 4'(div);
        clear_mon();
        pulse_probe();
        wait_done();
        check(aw_width == 4'(expw), (expw > 8) ? "R5 width no zero" : "R4 width", aw_width, expw);
        check(last_nb == 3 + ((expw > 8) ? 8 : expw), "R4 R5 edges in probe", last_nb, 3 + ((expw > 8) ? 8 : expw));
        check(hmin == div + 1 && hmax == div + 1, "R2 sk high phase", hmax, div + 1);
        check(lmin == div + 1 && lmax == div + 1, "R2 sk low phase", lmax, div + 1);
        check(txn == 1 && bad_op == 0, "R3 one transaction with opcode 110", txn * 10 + bad_op, 10);
        check(busy_gap == 0, "R10 busy held", busy_gap, 0);
        @(negedge clk);
        check(!ee_cs && !ee_sk && !ee_di && !busy, "R6 lines low after probe", {ee_cs, ee_sk, ee_di}, 0);
    endtask

    task automatic t_read(input int a, input int len, input int div, input int w);
        clk_div = 4'(div);
        clear_mon();
        pulse_read(a, len);
        wait_done();
        check(gi == len + 1, "R9 word count", gi, len + 1);
        for (int i = 0; i <= len && i < gi; i++)
            check(got[i] == mem(a + i), "R8 R7 word data", got[i], mem(a + i));
        check(txn == len + 1, "R9 one cs per word", txn, len + 1);
        check(last_nb == 3 + w + 16, "R7 R8 edges per word", last_nb, 3 + w + 16);
        check(bad_op == 0, "R3 opcode", bad_op, 0);
        check(busy_gap == 0, "R10 busy held", busy_gap, 0);
        @(negedge clk);
        check(!ee_cs && !ee_sk && !ee_di, "R6 lines low after read", {ee_cs, ee_sk, ee_di}, 0);
    endtask

    task automatic t_busy_ignore();
        dev_aw = 8; clk_div = 4'd0;
        clear_mon();
        pulse_probe();
        pulse_read(8'h33, 0);
        wait_done();
        repeat (20) @(negedge clk);
        check(gi == 0, "R10 read ignored while busy", gi, 0);
        check(txn == 1, "R10 only probe ran", txn, 1);
        check(!busy, "R10 idle after", busy, 0);
        check(aw_width == 4'd8, "R4 width after ignore", aw_width, 8);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        dev_aw = 6;
        t_read(8'h15, 0, 1, 6);      // R7 legacy width before probe
        t_probe(6, 0, 6);
        t_read(8'h2A, 0, 0, 6);
        t_probe(8, 2, 8);
        t_read(8'hC7, 2, 1, 8);      // R9 multi-word
        t_probe(10, 1, 9);           // R5
        t_busy_ignore();
        t_probe(6, 1, 6);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule